// File: doc/BRIEF.md
# Nine-Bit UART Address Filter

This block sits after a UART receiver that delivers 9-bit frames. The ninth bit, called the mark bit here, tags a frame as an address or ID frame. For each received frame the block decides whether to forward its 8-bit payload to the host. It does not forward frames whose mark bit has the wrong polarity. It can also open and close a delivery window, based on whether a marked frame carries the block's own ID byte.

Configuration is written through a strobe. The block accepts it only while the mode input selects configuration (reset) mode. The block filters frames only in run mode. Some combinations of configuration settings contradict each other. These raise a configuration-error flag, and no frames are delivered while that flag is set.

All outputs are registered. A frame presented on the input strobe leaves the block, or is dropped, one clock later. A one-clock pulse on a separate output reports each successful ID compare.

Top module: `uart9_addr_filter`

## Requirements
- R1: Synchronous reset clears `out_vld`, `id_hit`, `cfg_err`, the delivery window and all configuration fields to 0.
- R2: `cfg_wr` loads the configuration fields only when `run_mode` is 0. A `cfg_wr` while `run_mode` is 1 changes neither the configuration nor `cfg_err`.
- R3: `cfg_err` is 1 one cycle after a write in which any of these holds: `cfg_id_en`=1 with `cfg_mark_en`=0; `cfg_id_en`=1 with `cfg_cmp_off`=1; `cfg_buf_on`=1 with `cfg_id_en`=1; `cfg_buf_on`=1 with `cfg_cmp_off`=1. In every other case it is 0.
- R4: A frame (`rx_vld`=1) is dropped with no `out_vld` when `run_mode` is 0 or `cfg_err` is 1.
- R5: With `cfg_mark_en`=0, every frame is delivered. `out_vld` is high for one cycle, the cycle after `rx_vld`. In that cycle `out_data` = `rx_data[7:0]` and `out_mark` = `rx_data[8]`.
- R6: With `cfg_mark_en`=1 and `cfg_cmp_off`=1, every frame is delivered without looking at `rx_data[8]`.
- R7: With `cfg_mark_en`=1, `cfg_cmp_off`=0 and `cfg_id_en`=0, a frame is delivered if `rx_data[8]` equals `cfg_pol` and dropped otherwise.
- R8: With ID compare active (`cfg_mark_en`=1, `cfg_cmp_off`=0, `cfg_id_en`=1), a frame with `rx_data[8]`=`cfg_pol` is compared on its payload `rx_data[7:0]` against `cfg_id`. On a match the frame is delivered, `id_hit` pulses for one cycle together with `out_vld`, and the window opens. On a mismatch the frame is dropped and the window closes.
- R9: With ID compare active, a frame with `rx_data[8]` not equal to `cfg_pol` is delivered only while the window is open. Setting `run_mode` to 0 closes the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | 0 = configuration mode, 1 = run mode |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_mark_en | input | 1 | Enable mark-bit handling |
| cfg_cmp_off | input | 1 | Disable mark-bit polarity compare |
| cfg_id_en | input | 1 | Enable payload compare with ID after a marked frame |
| cfg_pol | input | 1 | Mark-bit value that tags an ID frame |
| cfg_buf_on | input | 1 | Receive buffer mode in use |
| cfg_id | input | 8 | ID byte |
| rx_vld | input | 1 | Received frame strobe |
| rx_data | input | 9 | Received frame, bit 8 is the mark bit |
| out_vld | output | 1 | Delivered frame strobe |
| out_data | output | 8 | Delivered payload |
| out_mark | output | 1 | Mark bit of the delivered frame |
| id_hit | output | 1 | One-cycle pulse on an ID match |
| cfg_err | output | 1 | Configuration conflict flag |

## Verification
Each frame's verdict is due exactly one cycle after its `rx_vld` cycle. This covers `out_vld`, `out_data`, `out_mark` and `id_hit`. `cfg_err` is due one cycle after the `cfg_wr` cycle. The bench drives inputs on the falling edge, holds them across one rising edge, and samples at the next falling edge. It also checks that `out_vld` is low again one cycle later, so a stretched strobe is reported. Dropped frames are checked in that same slot, by confirming that `out_vld` stayed low.

// File: rtl/u9f_pkg.sv
package u9f_pkg;

  typedef struct packed {
    logic mark_en;
    logic cmp_off;
    logic id_en;
    logic pol;
    logic buf_on;
  } u9f_flags_t;

  typedef enum logic [1:0] {
    V_DROP  = 2'd0,
    V_PASS  = 2'd1,
    V_HIT   = 2'd2,
    V_MISS  = 2'd3
  } u9f_verdict_t;

  function automatic logic flags_conflict(input u9f_flags_t f);
    logic id_bad;
    logic buf_bad;
    id_bad  = f.id_en && (!f.mark_en || f.cmp_off);
    buf_bad = f.buf_on && (f.id_en || f.cmp_off);
    return id_bad || buf_bad;
  endfunction

endpackage

// File: rtl/u9f_cfg_reg.sv
module u9f_cfg_reg
  import u9f_pkg::*;
#(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_mode,
  input  logic             wr,
  input  u9f_flags_t       flags_in,
  input  logic [PAY_W-1:0] id_in,
  output u9f_flags_t       flags_q,
  output logic [PAY_W-1:0] id_q,
  output logic             err_q
);

  logic wr_ok;
  assign wr_ok = wr && !run_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      id_q    <= '0;
      err_q   <= 1'b0;
    end else if (wr_ok) begin
      flags_q <= flags_in;
      id_q    <= id_in;
      err_q   <= flags_conflict(flags_in);
    end
  end

endmodule

// File: rtl/u9f_classify.sv
module u9f_classify
  import u9f_pkg::*;
#(
  parameter int PAY_W = 8
) (
  input  logic [PAY_W:0]   frame,
  input  u9f_flags_t       flags,
  input  logic [PAY_W-1:0] id,
  input  logic             window_open,
  output u9f_verdict_t     verdict
);

  logic marked;
  logic id_eq;

  assign marked = (frame[PAY_W] == flags.pol);
  assign id_eq  = (frame[PAY_W-1:0] == id);

  always_comb begin
    verdict = V_DROP;
    if (!flags.mark_en || flags.cmp_off) begin
      verdict = V_PASS;
    end else if (!flags.id_en) begin
      verdict = marked ? V_PASS : V_DROP;
    end else if (marked) begin
      verdict = id_eq ? V_HIT : V_MISS;
    end else begin
      verdict = window_open ? V_PASS : V_DROP;
    end
  end

endmodule

// File: rtl/u9f_gate.sv
module u9f_gate
  import u9f_pkg::*;
#(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_mode,
  input  logic             rx_vld,
  input  logic [PAY_W:0]   rx_data,
  input  logic             err,
  input  u9f_verdict_t     verdict,
  output logic             window_open,
  output logic             out_vld,
  output logic [PAY_W-1:0] out_data,
  output logic             out_mark,
  output logic             id_hit
);

  logic take;
  logic deliver;
  assign take    = rx_vld && run_mode && !err;
  assign deliver = take && ((verdict == V_PASS) || (verdict == V_HIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      window_open <= 1'b0;
      out_vld     <= 1'b0;
      out_data    <= '0;
      out_mark    <= 1'b0;
      id_hit      <= 1'b0;
    end else begin
      out_vld <= deliver;
      id_hit  <= take && (verdict == V_HIT);
      if (deliver) begin
        out_data <= rx_data[PAY_W-1:0];
        out_mark <= rx_data[PAY_W];
      end
      if (!run_mode) begin
        window_open <= 1'b0;
      end else if (take && verdict == V_HIT) begin
        window_open <= 1'b1;
      end else if (take && verdict == V_MISS) begin
        window_open <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart9_addr_filter.sv
module uart9_addr_filter
  import u9f_pkg::*;
#(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_mode,
  input  logic             cfg_wr,
  input  logic             cfg_mark_en,
  input  logic             cfg_cmp_off,
  input  logic             cfg_id_en,
  input  logic             cfg_pol,
  input  logic             cfg_buf_on,
  input  logic [PAY_W-1:0] cfg_id,
  input  logic             rx_vld,
  input  logic [PAY_W:0]   rx_data,
  output logic             out_vld,
  output logic [PAY_W-1:0] out_data,
  output logic             out_mark,
  output logic             id_hit,
  output logic             cfg_err
);

  u9f_flags_t       flags_in;
  u9f_flags_t       flags_q;
  logic [PAY_W-1:0] id_q;
  logic             window_open;
  u9f_verdict_t     verdict;

  assign flags_in = '{mark_en: cfg_mark_en, cmp_off: cfg_cmp_off,
                      id_en: cfg_id_en, pol: cfg_pol, buf_on: cfg_buf_on};

  u9f_cfg_reg #(.PAY_W(PAY_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .run_mode (run_mode),
    .wr       (cfg_wr),
    .flags_in (flags_in),
    .id_in    (cfg_id),
    .flags_q  (flags_q),
    .id_q     (id_q),
    .err_q    (cfg_err)
  );

  u9f_classify #(.PAY_W(PAY_W)) u_cls (
    .frame       (rx_data),
    .flags       (flags_q),
    .id          (id_q),
    .window_open (window_open),
    .verdict     (verdict)
  );

  u9f_gate #(.PAY_W(PAY_W)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .run_mode    (run_mode),
    .rx_vld      (rx_vld),
    .rx_data     (rx_data),
    .err         (cfg_err),
    .verdict     (verdict),
    .window_open (window_open),
    .out_vld     (out_vld),
    .out_data    (out_data),
    .out_mark    (out_mark),
    .id_hit      (id_hit)
  );

endmodule

// File: rtl/u9f_chk.sv
module u9f_chk (
  input logic clk,
  input logic rst,
  input logic run_mode,
  input logic rx_vld,
  input logic out_vld,
  input logic out_mark,
  input logic id_hit,
  input logic cfg_err,
  input logic mark_en_q,
  input logic cmp_off_q,
  input logic id_en_q,
  input logic pol_q
);

  // R4
  out_needs_frame_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ($past(rx_vld) && $past(run_mode)));

  // R4
  err_blocks_out_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !out_vld);

  // R2
  run_locks_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    run_mode |=> $stable(cfg_err));

  // R8
  hit_with_out_chk: assert property (@(posedge clk) disable iff (rst)
    id_hit |-> (out_vld && out_mark == pol_q && id_en_q));

  // R7
  pol_match_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && mark_en_q && !cmp_off_q && !id_en_q) |-> (out_mark == pol_q));

endmodule

bind uart9_addr_filter u9f_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .run_mode  (run_mode),
  .rx_vld    (rx_vld),
  .out_vld   (out_vld),
  .out_mark  (out_mark),
  .id_hit    (id_hit),
  .cfg_err   (cfg_err),
  .mark_en_q (flags_q.mark_en),
  .cmp_off_q (flags_q.cmp_off),
  .id_en_q   (flags_q.id_en),
  .pol_q     (flags_q.pol)
);

// File: tb/uart9_addr_filter_tb.sv
module uart9_addr_filter_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_mode = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_mark_en = 1'b0;
  logic       cfg_cmp_off = 1'b0;
  logic       cfg_id_en = 1'b0;
  logic       cfg_pol = 1'b0;
  logic       cfg_buf_on = 1'b0;
  logic [7:0] cfg_id = 8'h00;
  logic       rx_vld = 1'b0;
  logic [8:0] rx_data = 9'h000;
  logic       out_vld;
  logic [7:0] out_data;
  logic       out_mark;
  logic       id_hit;
  logic       cfg_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart9_addr_filter u_dut (
    .clk(clk), .rst(rst), .run_mode(run_mode), .cfg_wr(cfg_wr),
    .cfg_mark_en(cfg_mark_en), .cfg_cmp_off(cfg_cmp_off), .cfg_id_en(cfg_id_en),
    .cfg_pol(cfg_pol), .cfg_buf_on(cfg_buf_on), .cfg_id(cfg_id),
    .rx_vld(rx_vld), .rx_data(rx_data), .out_vld(out_vld), .out_data(out_data),
    .out_mark(out_mark), .id_hit(id_hit), .cfg_err(cfg_err)
  );

  // {cfg_sel[1:0], frame[8:0], exp_vld, exp_hit}
  // sel 0: mark off; 1: compare off; 2: polarity only; 3: ID compare (pol=1, id=5A)
  localparam int NV = 17;
  localparam logic [12:0] VEC [0:NV-1] = '{
    {2'd0, 9'h100, 1'b1, 1'b0},
    {2'd0, 9'h033, 1'b1, 1'b0},
    {2'd1, 9'h044, 1'b1, 1'b0},
    {2'd1, 9'h155, 1'b1, 1'b0},
    {2'd2, 9'h112, 1'b1, 1'b0},
    {2'd2, 9'h034, 1'b0, 1'b0},
    {2'd2, 9'h15A, 1'b1, 1'b0},
    {2'd3, 9'h011, 1'b0, 1'b0},
    {2'd3, 9'h15A, 1'b1, 1'b1},
    {2'd3, 9'h022, 1'b1, 1'b0},
    {2'd3, 9'h023, 1'b1, 1'b0},
    {2'd3, 9'h177, 1'b0, 1'b0},
    {2'd3, 9'h024, 1'b0, 1'b0},
    {2'd3, 9'h15A, 1'b1, 1'b1},
    {2'd3, 9'h099, 1'b1, 1'b0},
    {2'd3, 9'h15B, 1'b0, 1'b0},
    {2'd3, 9'h0A0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic me, input logic co, input logic ie,
                           input logic po, input logic bo, input logic [7:0] id);
    @(negedge clk);
    cfg_mark_en = me; cfg_cmp_off = co; cfg_id_en = ie;
    cfg_pol = po; cfg_buf_on = bo; cfg_id = id; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic apply_sel(input logic [1:0] sel);
    @(negedge clk);
    run_mode = 1'b0;
    case (sel)
      2'd0: write_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
      2'd1: write_cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A);
      2'd2: write_cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
      default: write_cfg(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h5A);
    endcase
    run_mode = 1'b1;
  endtask

  // drive one frame; on return outputs show the verdict (one cycle later)
  task automatic send(input logic [8:0] f);
    @(negedge clk);
    rx_vld = 1'b1; rx_data = f;
    @(negedge clk);
    rx_vld = 1'b0;
  endtask

  task automatic frame_chk(input string req, input logic [8:0] f,
                           input logic ev, input logic eh);
    send(f);
    chk(req, {31'd0, out_vld}, {31'd0, ev});
    chk(req, {31'd0, id_hit}, {31'd0, eh});
    if (ev) begin
      chk(req, {24'd0, out_data}, {24'd0, f[7:0]});
      chk(req, {31'd0, out_mark}, {31'd0, f[8]});
    end
    @(negedge clk);
    chk(req, {30'd0, out_vld, id_hit}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {29'd0, out_vld, id_hit, cfg_err}, 32'd0);

    // table walk
    begin
      logic [1:0] cur;
      cur = 2'd3;
      apply_sel(2'd0);
      cur = 2'd0;
      for (int i = 0; i < NV; i++) begin
        logic [1:0] s;
        s = VEC[i][12:11];
        if (s != cur) begin
          apply_sel(s);
          cur = s;
        end
        case (s)
          2'd0: frame_chk("R5", VEC[i][10:2], VEC[i][1], VEC[i][0]);
          2'd1: frame_chk("R6", VEC[i][10:2], VEC[i][1], VEC[i][0]);
          2'd2: frame_chk("R7", VEC[i][10:2], VEC[i][1], VEC[i][0]);
          default: frame_chk("R8_R9", VEC[i][10:2], VEC[i][1], VEC[i][0]);
        endcase
      end
    end

    // R9 leaving run mode closes the window
    apply_sel(2'd3);
    frame_chk("R8", 9'h15A, 1'b1, 1'b1);
    frame_chk("R9", 9'h031, 1'b1, 1'b0);
    @(negedge clk); run_mode = 1'b0;
    @(negedge clk); run_mode = 1'b1;
    frame_chk("R9", 9'h032, 1'b0, 1'b0);

    // R4 frame in configuration mode is dropped
    @(negedge clk); run_mode = 1'b0;
    write_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    frame_chk("R4", 9'h0C3, 1'b0, 1'b0);

    // R3 conflict combinations
    write_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R3", {31'd0, cfg_err}, 32'd1);
    write_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R3", {31'd0, cfg_err}, 32'd0);
    write_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R3", {31'd0, cfg_err}, 32'd1);
    write_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R3", {31'd0, cfg_err}, 32'd0);
    write_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R3", {31'd0, cfg_err}, 32'd1);
    write_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R3", {31'd0, cfg_err}, 32'd1);
    write_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R3", {31'd0, cfg_err}, 32'd0);

    // R4 error blocks delivery in run mode
    write_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    run_mode = 1'b1;
    frame_chk("R4", 9'h0E1, 1'b0, 1'b0);

    // R2 writes ignored in run mode: fix config clean, then try to spoil it
    @(negedge clk); run_mode = 1'b0;
    write_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    run_mode = 1'b1;
    write_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);
    chk("R2", {31'd0, cfg_err}, 32'd0);
    // polarity still 0 from the earlier write
    frame_chk("R2", 9'h042, 1'b1, 1'b0);
    frame_chk("R2", 9'h142, 1'b0, 1'b0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule